// File: doc/BRIEF.md
# Sync Lane Frame Decoder

This block sits behind the word aligner of a multi-lane serial image link. On each word clock it takes one aligned 10-bit word from the sync lane, which runs beside the pixel lanes, and works out what the pixel lanes are carrying in that same word slot. It recognises the four framing codes (window frame open, window frame close, line open, line close), the window number word that follows each framing code, training words, CRC markers and the two pixel marker codes. All code values are parameters.

From that stream the block keeps the framing state: which windows have an open frame, whether a line is in progress, and whether that line is a black calibration line. It registers a set of per-word flags for the pixel lanes: frame and line activity, black line, the current window number, and one-word pulses for each framing event. Any word that breaks the framing rules sets a sticky error flag that holds until reset. The data lanes carry valid pixels during the framing code and window number words, so those words count as part of the line.

Top module: `sync_frame_decoder`

## Requirements
- R1: A line-open code (default 0x2C8) accepted while no line is open gives a `lineStart` pulse and sets `lineActive` from that word through the window number word that follows the matching line-close code (default 0x2CC), which gives a `lineEnd` pulse; the word after that shows `lineActive` low.
- R2: A frame-open code (default 0x2C0) accepted while no line is open gives a `frameStart` pulse, and `frameActive` and `lineActive` are high on that word and on its window number word; at most one of the seven event pulses is high on any output cycle.
- R3: The word after any accepted framing code is always taken as the window number and gives an `idFlag` pulse; for a non-black line its value (0 to NUM_WIN-1) appears on `windowId` in that output cycle, and a value of NUM_WIN or above sets the error flag and leaves `windowId` unchanged.
- R4: A frame-close code (default 0x2C4) closes both the line and the named window once its window number word has been taken; `frameActive` falls on the next word when no other window is open.
- R5: A line-open code seen while no window frame is open starts a black line: `blackLine` is high together with `lineActive` for every word of that line, and its window number word does not change `windowId`.
- R6: A training word (default 0x3A9) gives a `trainFlag` pulse with `frameActive`, `lineActive` and `blackLine` all low for that word, and leaves the framing state as it was, so the next pixel word shows the flags from before the training word.
- R7: A CRC marker (default 0x250) gives a `crcFlag` pulse and leaves the activity flags unchanged.
- R8: Windows may overlap: a frame-open code for a second window while the first is still open is accepted, and `frameActive` stays high until the last open window has been closed.
- R9: `protoErr` is set and stays set until reset by any of: a line-close or frame-close code with no line open, a frame-close code on a black line, a frame-open or line-open code while a line is open, a word that matches no code where a code is expected, or an out-of-range window number. A rejected code gives no event pulse and changes no state.
- R10: During and right after reset every output is low and `windowId` is 0.
- R11: `outValid` follows `wordValid` one cycle later; a cycle with `wordValid` low gives no pulses, and the activity flags and `windowId` keep their values.
- R12: Normal pixel markers (default 0x200) and black pixel markers (default 0x210) give no pulse and no error and leave the flags unchanged, inside or outside a line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wordValid | input | 1 | A sync lane word is present this cycle |
| syncWord | input | DATA_W | Aligned sync lane word |
| outValid | output | 1 | Output flags belong to a word taken on the previous edge |
| frameActive | output | 1 | At least one window frame is open for this word |
| lineActive | output | 1 | The word belongs to a line |
| blackLine | output | 1 | The word belongs to a black line |
| windowId | output | ID_BITS | Current window number |
| frameStart | output | 1 | Pulse: accepted frame-open code |
| frameEnd | output | 1 | Pulse: accepted frame-close code |
| lineStart | output | 1 | Pulse: accepted line-open code |
| lineEnd | output | 1 | Pulse: accepted line-close code |
| idFlag | output | 1 | Pulse: window number word |
| crcFlag | output | 1 | Pulse: CRC marker word |
| trainFlag | output | 1 | Pulse: training word |
| protoErr | output | 1 | Sticky framing error |

## Verification
The bench aims at the places where the framing state is easy to get off by one word. It checks that the line stays active through the window number after a close code, since a design that closed on the code itself would cut the last pixel word. It checks that a training word in the middle of a line blanks only its own word, which a design that cleared the state would fail by dropping the line. It also checks that a black line's window number leaves `windowId` alone, and that with two overlapping windows the frame stays open after the first one closes. Error cases run one per reset because the flag is sticky: a close with no open line, a word that matches no code, a window number out of range, and a frame close on a black line. A design that let a rejected code through would pulse or change state there.

// File: rtl/syncdec_pkg.sv
package syncdec_pkg;

  typedef enum logic [3:0] {
    K_FS, K_FE, K_LS, K_LE, K_ID, K_TRAIN, K_CRC, K_PIX, K_BAD
  } wordKind_e;

  typedef enum logic [1:0] {P_FS, P_FE, P_LS, P_LE} pendCode_e;

  typedef struct packed {
    logic wordStb;
    logic setWin;
    logic clrWin;
    logic loadId;
    logic errSet;
    logic frameAct;
    logic lineAct;
    logic black;
    logic fsPulse;
    logic fePulse;
    logic lsPulse;
    logic lePulse;
    logic idPulse;
    logic crcPulse;
    logic trainPulse;
  } ctlStrobe_t;

endpackage

// File: rtl/syncdec_ctrl.sv
module syncdec_ctrl
  import syncdec_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_WIN = 32,
  parameter logic [DATA_W-1:0] CODE_FS = 10'h2C0,
  parameter logic [DATA_W-1:0] CODE_FE = 10'h2C4,
  parameter logic [DATA_W-1:0] CODE_LS = 10'h2C8,
  parameter logic [DATA_W-1:0] CODE_LE = 10'h2CC,
  parameter logic [DATA_W-1:0] CODE_TRAIN = 10'h3A9,
  parameter logic [DATA_W-1:0] CODE_CRC = 10'h250,
  parameter logic [DATA_W-1:0] CODE_PIX = 10'h200,
  parameter logic [DATA_W-1:0] CODE_BLK = 10'h210
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] syncWord,
  input  logic              anyOpen,
  input  logic              idOpen,
  output ctlStrobe_t        stb
);

  localparam logic [DATA_W-1:0] ID_LIMIT = DATA_W'(NUM_WIN);

  logic      inLine, lineBlack, expectId;
  pendCode_e pend;
  logic      nInLine, nBlack, nExpect;
  pendCode_e nPend;
  wordKind_e kind;
  logic      idOk;

  function automatic wordKind_e classify(input logic [DATA_W-1:0] w);
    if (w == CODE_FS)         return K_FS;
    else if (w == CODE_FE)    return K_FE;
    else if (w == CODE_LS)    return K_LS;
    else if (w == CODE_LE)    return K_LE;
    else if (w == CODE_TRAIN) return K_TRAIN;
    else if (w == CODE_CRC)   return K_CRC;
    else if (w == CODE_PIX || w == CODE_BLK) return K_PIX;
    else                      return K_BAD;
  endfunction

  assign kind = expectId ? K_ID : classify(syncWord);
  assign idOk = (syncWord < ID_LIMIT);

  always_comb begin
    stb          = '0;
    nInLine      = inLine;
    nBlack       = lineBlack;
    nExpect      = expectId;
    nPend        = pend;
    stb.wordStb  = wordValid;
    stb.frameAct = anyOpen;
    stb.lineAct  = inLine;
    stb.black    = inLine & lineBlack;
    if (wordValid) begin
      unique case (kind)
        K_FS: begin
          if (inLine) stb.errSet = 1'b1;
          else begin
            stb.fsPulse  = 1'b1;
            stb.frameAct = 1'b1;
            stb.lineAct  = 1'b1;
            stb.black    = 1'b0;
            nInLine = 1'b1;
            nBlack  = 1'b0;
            nExpect = 1'b1;
            nPend   = P_FS;
          end
        end
        K_LS: begin
          if (inLine) stb.errSet = 1'b1;
          else begin
            stb.lsPulse = 1'b1;
            stb.lineAct = 1'b1;
            stb.black   = ~anyOpen;
            nInLine = 1'b1;
            nBlack  = ~anyOpen;
            nExpect = 1'b1;
            nPend   = P_LS;
          end
        end
        K_LE: begin
          if (!inLine) stb.errSet = 1'b1;
          else begin
            stb.lePulse = 1'b1;
            nExpect = 1'b1;
            nPend   = P_LE;
          end
        end
        K_FE: begin
          if (!inLine || lineBlack) stb.errSet = 1'b1;
          else begin
            stb.fePulse = 1'b1;
            nExpect = 1'b1;
            nPend   = P_FE;
          end
        end
        K_ID: begin
          stb.idPulse = 1'b1;
          nExpect = 1'b0;
          if (pend == P_FS) stb.frameAct = 1'b1;
          if (!idOk) stb.errSet = 1'b1;
          else begin
            unique case (pend)
              P_FS: begin
                if (idOpen) stb.errSet = 1'b1;
                else begin
                  stb.setWin = 1'b1;
                  stb.loadId = 1'b1;
                end
              end
              P_LS: begin
                if (!lineBlack) begin
                  if (!idOpen) stb.errSet = 1'b1;
                  else stb.loadId = 1'b1;
                end
              end
              P_FE: begin
                if (!idOpen) stb.errSet = 1'b1;
                else stb.clrWin = 1'b1;
              end
              P_LE: ;
              default: ;
            endcase
          end
          if (pend == P_LE || pend == P_FE) nInLine = 1'b0;
        end
        K_TRAIN: begin
          stb.trainPulse = 1'b1;
          stb.frameAct   = 1'b0;
          stb.lineAct    = 1'b0;
          stb.black      = 1'b0;
        end
        K_CRC: stb.crcPulse = 1'b1;
        K_PIX: ;
        K_BAD: stb.errSet = 1'b1;
        default: stb.errSet = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inLine    <= 1'b0;
      lineBlack <= 1'b0;
      expectId  <= 1'b0;
      pend      <= P_LS;
    end else begin
      inLine    <= nInLine;
      lineBlack <= nBlack;
      expectId  <= nExpect;
      pend      <= nPend;
    end
  end

  // R4: a taken frame-close window number ends the line
  assert_fe_closes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && expectId && pend == P_FE) |=> !inLine);

  // R5: a line opened with no frame open is black
  assert_black_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && !expectId && kind == K_LS && !inLine && !anyOpen) |=> (inLine && lineBlack));

  // R3: an accepted frame-open code is always followed by a window number slot
  assert_code_then_id_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.fsPulse || stb.lsPulse) |=> expectId);

endmodule

// File: rtl/syncdec_dp.sv
module syncdec_dp
  import syncdec_pkg::*;
#(
  parameter int NUM_WIN = 32,
  parameter int ID_BITS = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stb,
  input  logic [ID_BITS-1:0] idIdx,
  output logic               anyOpen,
  output logic               idOpen,
  output logic               outValid,
  output logic               frameActive,
  output logic               lineActive,
  output logic               blackLine,
  output logic [ID_BITS-1:0] windowId,
  output logic               frameStart,
  output logic               frameEnd,
  output logic               lineStart,
  output logic               lineEnd,
  output logic               idFlag,
  output logic               crcFlag,
  output logic               trainFlag,
  output logic               protoErr
);

  logic [NUM_WIN-1:0] openMask;
  logic [NUM_WIN-1:0] winSel;

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    assign winSel[g] = (idIdx == ID_BITS'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          openMask[g] <= 1'b0;
      else if (stb.setWin && winSel[g])   openMask[g] <= 1'b1;
      else if (stb.clrWin && winSel[g])   openMask[g] <= 1'b0;
    end
  end

  assign anyOpen = |openMask;
  assign idOpen  = |(openMask & winSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      frameActive <= 1'b0;
      lineActive  <= 1'b0;
      blackLine   <= 1'b0;
      windowId    <= '0;
      frameStart  <= 1'b0;
      frameEnd    <= 1'b0;
      lineStart   <= 1'b0;
      lineEnd     <= 1'b0;
      idFlag      <= 1'b0;
      crcFlag     <= 1'b0;
      trainFlag   <= 1'b0;
      protoErr    <= 1'b0;
    end else begin
      outValid   <= stb.wordStb;
      frameStart <= stb.fsPulse;
      frameEnd   <= stb.fePulse;
      lineStart  <= stb.lsPulse;
      lineEnd    <= stb.lePulse;
      idFlag     <= stb.idPulse;
      crcFlag    <= stb.crcPulse;
      trainFlag  <= stb.trainPulse;
      if (stb.wordStb) begin
        frameActive <= stb.frameAct;
        lineActive  <= stb.lineAct;
        blackLine   <= stb.black;
      end
      if (stb.loadId) windowId <= idIdx;
      if (stb.errSet) protoErr <= 1'b1;
    end
  end

  // R9: the error flag never clears outside reset
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  // R2: event pulses are mutually exclusive
  assert_pulse_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({frameStart, frameEnd, lineStart, lineEnd, idFlag, crcFlag, trainFlag}));

  // R6: a training word shows idle flags
  assert_train_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    trainFlag |-> (!frameActive && !lineActive && !blackLine));

  // R11: no word, no pulse
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !(frameStart || frameEnd || lineStart || lineEnd || idFlag || crcFlag || trainFlag));

  // R3: the window number only moves on a window number word
  assert_id_moves_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(windowId) |-> idFlag);

  // R5: black only inside a line
  assert_black_in_line_R5: assert property (@(posedge clk) disable iff (!rstN)
    blackLine |-> lineActive);

endmodule

// File: rtl/sync_frame_decoder.sv
module sync_frame_decoder
  import syncdec_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int NUM_WIN = 32,
  parameter int ID_BITS = $clog2(NUM_WIN),
  parameter logic [DATA_W-1:0] CODE_FS = 10'h2C0,
  parameter logic [DATA_W-1:0] CODE_FE = 10'h2C4,
  parameter logic [DATA_W-1:0] CODE_LS = 10'h2C8,
  parameter logic [DATA_W-1:0] CODE_LE = 10'h2CC,
  parameter logic [DATA_W-1:0] CODE_TRAIN = 10'h3A9,
  parameter logic [DATA_W-1:0] CODE_CRC = 10'h250,
  parameter logic [DATA_W-1:0] CODE_PIX = 10'h200,
  parameter logic [DATA_W-1:0] CODE_BLK = 10'h210
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wordValid,
  input  logic [DATA_W-1:0]  syncWord,
  output logic               outValid,
  output logic               frameActive,
  output logic               lineActive,
  output logic               blackLine,
  output logic [ID_BITS-1:0] windowId,
  output logic               frameStart,
  output logic               frameEnd,
  output logic               lineStart,
  output logic               lineEnd,
  output logic               idFlag,
  output logic               crcFlag,
  output logic               trainFlag,
  output logic               protoErr
);

  ctlStrobe_t stb;
  logic       anyOpen, idOpen;

  syncdec_ctrl #(
    .DATA_W(DATA_W), .NUM_WIN(NUM_WIN),
    .CODE_FS(CODE_FS), .CODE_FE(CODE_FE), .CODE_LS(CODE_LS), .CODE_LE(CODE_LE),
    .CODE_TRAIN(CODE_TRAIN), .CODE_CRC(CODE_CRC), .CODE_PIX(CODE_PIX), .CODE_BLK(CODE_BLK)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .syncWord(syncWord),
    .anyOpen(anyOpen), .idOpen(idOpen), .stb(stb)
  );

  syncdec_dp #(.NUM_WIN(NUM_WIN), .ID_BITS(ID_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idIdx(syncWord[ID_BITS-1:0]),
    .anyOpen(anyOpen), .idOpen(idOpen),
    .outValid(outValid), .frameActive(frameActive), .lineActive(lineActive),
    .blackLine(blackLine), .windowId(windowId),
    .frameStart(frameStart), .frameEnd(frameEnd), .lineStart(lineStart), .lineEnd(lineEnd),
    .idFlag(idFlag), .crcFlag(crcFlag), .trainFlag(trainFlag), .protoErr(protoErr)
  );

endmodule

// File: tb/sync_frame_decoder_bench.sv
`timescale 1ns/1ps
module sync_frame_decoder_bench;

  localparam logic [9:0] W_FS = 10'h2C0, W_FE = 10'h2C4, W_LS = 10'h2C8, W_LE = 10'h2CC;
  localparam logic [9:0] W_TR = 10'h3A9, W_CRC = 10'h250, W_PIX = 10'h200, W_BLK = 10'h210;
  // pulse order {frameStart, frameEnd, lineStart, lineEnd, idFlag, crcFlag, trainFlag}
  localparam logic [6:0] NP = 7'b0, PFS = 7'b1000000, PFE = 7'b0100000, PLS = 7'b0010000;
  localparam logic [6:0] PLE = 7'b0001000, PID = 7'b0000100, PCRC = 7'b0000010, PTR = 7'b0000001;

  typedef struct {
    string      req;
    logic       f, l, b, e;
    logic [4:0] id;
    logic [6:0] p;
  } expItem_t;

  logic clk = 1'b0, rstN = 1'b0, wordValid = 1'b0;
  logic [9:0] syncWord = '0;
  logic outValid, frameActive, lineActive, blackLine;
  logic [4:0] windowId;
  logic frameStart, frameEnd, lineStart, lineEnd, idFlag, crcFlag, trainFlag, protoErr;

  int checks = 0, fails = 0;
  expItem_t q[$];
  expItem_t lastExp;

  always #2.5 clk = ~clk;

  sync_frame_decoder u_sync_frame_decoder (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .syncWord(syncWord),
    .outValid(outValid), .frameActive(frameActive), .lineActive(lineActive),
    .blackLine(blackLine), .windowId(windowId), .frameStart(frameStart),
    .frameEnd(frameEnd), .lineStart(lineStart), .lineEnd(lineEnd), .idFlag(idFlag),
    .crcFlag(crcFlag), .trainFlag(trainFlag), .protoErr(protoErr)
  );

  wire [6:0] pulses = {frameStart, frameEnd, lineStart, lineEnd, idFlag, crcFlag, trainFlag};

  // monitor: pop one expected item per output word
  always @(negedge clk) begin
    if (rstN && outValid) begin
      checks++;
      if (q.size() == 0) begin
        fails++;
        $display("FAIL unexpected output word: f%b l%b b%b id%0d p%b e%b, expected none",
                 frameActive, lineActive, blackLine, windowId, pulses, protoErr);
      end else begin
        expItem_t x;
        x = q.pop_front();
        lastExp = x;
        if ({frameActive, lineActive, blackLine, windowId, pulses, protoErr} !==
            {x.f, x.l, x.b, x.id, x.p, x.e}) begin
          fails++;
          $display("FAIL %s: got f%b l%b b%b id%0d p%b e%b, expected f%b l%b b%b id%0d p%b e%b",
                   x.req, frameActive, lineActive, blackLine, windowId, pulses, protoErr,
                   x.f, x.l, x.b, x.id, x.p, x.e);
        end
      end
    end
  end

  task automatic send(input logic [9:0] w, input string r, input logic f, input logic l,
                      input logic b, input logic [4:0] id, input logic [6:0] p, input logic e);
    expItem_t x;
    @(negedge clk);
    wordValid = 1'b1;
    syncWord  = w;
    x.req = r; x.f = f; x.l = l; x.b = b; x.id = id; x.p = p; x.e = e;
    q.push_back(x);
  endtask

  task automatic gap(input int n);
    @(negedge clk);
    wordValid = 1'b0;
    syncWord  = 10'h155;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (outValid !== 1'b0 || pulses !== NP || frameActive !== lastExp.f ||
          lineActive !== lastExp.l || windowId !== lastExp.id) begin
        fails++;
        $display("FAIL R11 idle cycle: got v%b p%b f%b l%b id%0d, expected v0 p0 f%b l%b id%0d",
                 outValid, pulses, frameActive, lineActive, windowId,
                 lastExp.f, lastExp.l, lastExp.id);
      end
    end
  endtask

  task automatic doReset();
    gap(1);
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    checks++;
    if ({outValid, frameActive, lineActive, blackLine, windowId, pulses, protoErr} !== '0) begin
      fails++;
      $display("FAIL R10 reset state: got v%b f%b l%b b%b id%0d p%b e%b, expected all zero",
               outValid, frameActive, lineActive, blackLine, windowId, pulses, protoErr);
    end
    rstN = 1'b1;
    lastExp.f = 0; lastExp.l = 0; lastExp.b = 0; lastExp.id = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    lastExp.f = 0; lastExp.l = 0; lastExp.b = 0; lastExp.id = 0;
    repeat (3) @(negedge clk);
    checks++;
    if ({outValid, frameActive, lineActive, blackLine, windowId, pulses, protoErr} !== '0) begin
      fails++;
      $display("FAIL R10 reset state: got nonzero outputs, expected all zero");
    end
    rstN = 1'b1;

    send(W_TR,  "R6 idle training",      0,0,0, 0, PTR, 0);
    // black line before any window frame
    send(W_LS,  "R5 black line open",    0,1,1, 0, PLS, 0);
    send(5'd7,  "R5 black id ignored",   0,1,1, 0, PID, 0);
    send(W_BLK, "R12 black pixel",       0,1,1, 0, NP,  0);
    send(W_CRC, "R7 crc in black line",  0,1,1, 0, PCRC,0);
    send(W_LE,  "R1 black line close",   0,1,1, 0, PLE, 0);
    send(5'd7,  "R1 close id in line",   0,1,1, 0, PID, 0);
    send(W_PIX, "R12 pixel outside line",0,0,0, 0, NP,  0);
    // window 2 first line
    send(W_FS,  "R2 frame open",         1,1,0, 0, PFS, 0);
    send(5'd2,  "R3 frame id loads",     1,1,0, 2, PID, 0);
    send(W_PIX, "R12 pixel in line",     1,1,0, 2, NP,  0);
    send(W_TR,  "R6 training mid line",  0,0,0, 2, PTR, 0);
    send(W_PIX, "R6 state kept",         1,1,0, 2, NP,  0);
    send(W_CRC, "R7 crc in line",        1,1,0, 2, PCRC,0);
    send(W_LE,  "R1 line close",         1,1,0, 2, PLE, 0);
    send(5'd2,  "R1 close id",           1,1,0, 2, PID, 0);
    send(W_PIX, "R1 line ended",         1,0,0, 2, NP,  0);
    gap(2);
    // overlap with window 5
    send(W_LS,  "R1 line open",          1,1,0, 2, PLS, 0);
    send(5'd2,  "R3 line id",            1,1,0, 2, PID, 0);
    send(W_LE,  "R1 line close",         1,1,0, 2, PLE, 0);
    send(5'd2,  "R1 close id",           1,1,0, 2, PID, 0);
    send(W_FS,  "R8 second frame open",  1,1,0, 2, PFS, 0);
    send(5'd5,  "R8 second frame id",    1,1,0, 5, PID, 0);
    send(W_LE,  "R1 line close",         1,1,0, 5, PLE, 0);
    send(5'd5,  "R1 close id",           1,1,0, 5, PID, 0);
    send(W_LS,  "R1 line open",          1,1,0, 5, PLS, 0);
    send(5'd2,  "R3 id switches",        1,1,0, 2, PID, 0);
    send(W_FE,  "R4 frame close",        1,1,0, 2, PFE, 0);
    send(5'd2,  "R4 close id",           1,1,0, 2, PID, 0);
    send(W_PIX, "R8 frame still open",   1,0,0, 2, NP,  0);
    send(W_LS,  "R1 line open",          1,1,0, 2, PLS, 0);
    send(5'd5,  "R3 id switches",        1,1,0, 5, PID, 0);
    send(W_FE,  "R4 frame close",        1,1,0, 5, PFE, 0);
    send(5'd5,  "R4 close id",           1,1,0, 5, PID, 0);
    send(W_PIX, "R4 all frames closed",  0,0,0, 5, NP,  0);
    // black line after frames: id stays
    send(W_LS,  "R5 black line open",    0,1,1, 5, PLS, 0);
    send(5'd3,  "R5 black id ignored",   0,1,1, 5, PID, 0);
    send(W_LE,  "R5 black close",        0,1,1, 5, PLE, 0);
    send(5'd3,  "R5 black close id",     0,1,1, 5, PID, 0);
    // error: line close with no line
    send(W_LE,  "R9 close without line", 0,0,0, 5, NP,  1);
    send(W_PIX, "R9 error sticky",       0,0,0, 5, NP,  1);
    doReset();
    // error: window number where a code is expected
    send(5'd4,  "R9 stray id word",      0,0,0, 0, NP,  1);
    doReset();
    // error: out of range window number
    send(W_FS,  "R2 frame open",         1,1,0, 0, PFS, 0);
    send(10'd40,"R3 id out of range",    1,1,0, 0, PID, 1);
    doReset();
    // error: frame close on black line
    send(W_LS,  "R5 black line open",    0,1,1, 0, PLS, 0);
    send(5'd1,  "R5 black id ignored",   0,1,1, 0, PID, 0);
    send(W_FE,  "R9 frame close on black",0,1,1,0, NP,  1);
    gap(3);
    checks++;
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R11 outputs missing: got %0d pending, expected 0", q.size());
    end
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule